// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Flag Shadowing

This block chooses which interrupt a small processor core services next. It latches request pulses from a parameterized number of maskable sources (four by default) and from one nonmaskable source. Each cycle it decides whether an interrupt may be taken and, if so, which one. The result is a take strobe together with a vector index. Maskable sources are ranked by index, with the lowest index winning, and are admitted only while the global enable flag is set. The nonmaskable source ignores that flag and outranks every maskable source. A defer input from the core holds off every take while the core is in a delayed branch or a multicycle operation.

The block also owns the global enable flag and the carry flag, plus a shadow copy of each. Taking an interrupt saves both flags into their shadows and clears the enable. A return pulse from the core copies the shadows back. The core can also set or clear the enable and write the carry directly. Those writes rank below a take and below a return in the same cycle.

Top module: `intr_prio_ctrl`

## Requirements
- R1: A high bit k on `req_i` in a cycle sets pending flag k at the next clock edge, shown on `pend_o[k]`. The flag then stays set until that source is taken.
- R2: When maskable sources are eligible, the lowest-numbered pending flag wins, and `vec_o` carries its index (0 to N_MASK-1).
- R3: A pulse on `nmi_i` sets a nonmaskable latch (`nmi_pend_o`) at the next edge. While that latch is set and defer is low, the nonmaskable source is taken whatever the enable flag holds. It beats all maskable flags and is reported as `vec_o` = N_MASK (4 by default).
- R4: While `defer_i` is high, `take_o` is low and no pending flag or latch is cleared. The held interrupt is taken in the first cycle that `defer_i` is low.
- R5: `take_o` is combinational from the registered state and `defer_i`. At the clock edge that ends a take cycle, the winner's pending flag or latch clears. A new request for the same source in that same cycle sets it again.
- R6: At the edge ending a take cycle, the enable flag becomes 0, the previous-enable shadow receives the old enable, and the previous-carry shadow receives the old carry.
- R7: A `reti_i` pulse in a cycle without a take loads the enable from the previous-enable shadow and the carry from the previous-carry shadow. If a take falls in the same cycle, the return pulse is ignored.
- R8: Without a take or a return, `gie_set_i` sets the enable and `gie_clr_i` clears it at the next edge. When both are high, clear wins.
- R9: `carry_we_i` loads `carry_d_i` into the carry flag at the next edge unless a return in that cycle restores the carry. A take does not block the write.
- R10: During and right after reset, every pending flag, the latch, the enable, the carry and both shadows are 0, and `take_o` is low.
- R11: While the enable is 0, maskable flags are not taken and stay pending; only the nonmaskable latch can produce a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASK | Maskable request pulses |
| nmi_i | input | 1 | Nonmaskable request pulse |
| defer_i | input | 1 | Core busy with a delayed branch or multicycle operation |
| reti_i | input | 1 | Return-from-interrupt pulse |
| gie_set_i | input | 1 | Direct set of the enable flag |
| gie_clr_i | input | 1 | Direct clear of the enable flag |
| carry_we_i | input | 1 | Carry write strobe |
| carry_d_i | input | 1 | Carry write data |
| take_o | output | 1 | An interrupt is taken this cycle |
| vec_o | output | $clog2(N_MASK+1) | Index of the taken interrupt |
| gie_o | output | 1 | Global enable flag |
| pgie_o | output | 1 | Previous-enable shadow |
| carry_o | output | 1 | Carry flag |
| pcarry_o | output | 1 | Previous-carry shadow |
| pend_o | output | N_MASK | Maskable pending flags |
| nmi_pend_o | output | 1 | Nonmaskable latch |

## Verification
Any fault in a pending flag or in the nonmaskable latch shows up on `pend_o` or `nmi_pend_o` one edge later. It also changes `take_o` or `vec_o` during the very next cycle that is eligible to take. A wrong enable or shadow value appears on the flag outputs right away. It also stays hidden inside the shadows until a later return exposes it, so the bench drives take and return cycles back to back for every combination of enable and carry. The sweep covers every pattern of four pending flags, with the nonmaskable latch present and absent and with defer asserted and released. For each pattern, a bench model checks each outcome in the same cycle it appears.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

   // Which rule updates the flag set in a cycle, highest precedence first.
   typedef enum logic [1:0] {
      FLG_TAKE   = 2'd0,
      FLG_RETURN = 2'd1,
      FLG_WRITE  = 2'd2
   } flag_src_e;

   typedef struct packed {
      logic gie;
      logic pgie;
      logic carry;
      logic pcarry;
   } flag_set_t;

   localparam flag_set_t FLAGS_RESET = '{gie: 1'b0, pgie: 1'b0, carry: 1'b0, pcarry: 1'b0};

   localparam int unsigned PICK_SCAN   = 0;
   localparam int unsigned PICK_ISOLATE = 1;

endpackage

// File: rtl/intr_req_latch.sv
module intr_req_latch #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("intr_req_latch: WIDTH must be at least 1");
   end

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else begin
            // a fresh request outranks the clear of the one being taken
            flag_q <= (flag_q & ~clr_i[k]) | set_i[k];
         end
      end
      assign pend_o[k] = flag_q;
   end

endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned STYLE = 0
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [WIDTH-1:0] onehot_o
);
   import intr_prio_pkg::*;

   if (IDX_W < $clog2(WIDTH)) begin : g_bad_idx
      $error("intr_prio_pick: IDX_W too narrow for WIDTH");
   end
   if (STYLE != PICK_SCAN && STYLE != PICK_ISOLATE) begin : g_bad_style
      $error("intr_prio_pick: unknown STYLE");
   end

   assign any_o = |req_i;

   if (STYLE == PICK_SCAN) begin : g_scan
      // Walk from the top down so the lowest set index is written last.
      always_comb begin
         idx_o    = '0;
         onehot_o = '0;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               idx_o    = IDX_W'(i);
               onehot_o = WIDTH'(1) << i;
            end
         end
      end
   end else begin : g_isolate
      // Two's-complement trick keeps only the lowest set bit, then encode it.
      logic [WIDTH-1:0] low_bit;
      assign low_bit  = req_i & (~req_i + WIDTH'(1));
      assign onehot_o = low_bit;
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (low_bit[i]) begin
               idx_o = idx_o | IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take_i,
   input  logic                     reti_i,
   input  logic                     gie_set_i,
   input  logic                     gie_clr_i,
   input  logic                     carry_we_i,
   input  logic                     carry_d_i,
   output intr_prio_pkg::flag_set_t flags_o
);
   import intr_prio_pkg::*;

   flag_set_t flags_q;
   flag_set_t flags_d;
   flag_src_e src;

   always_comb begin
      if (take_i) begin
         src = FLG_TAKE;
      end else if (reti_i) begin
         src = FLG_RETURN;
      end else begin
         src = FLG_WRITE;
      end
   end

   always_comb begin
      flags_d = flags_q;
      unique case (src)
         FLG_TAKE: begin
            flags_d.pgie   = flags_q.gie;
            flags_d.pcarry = flags_q.carry;
            flags_d.gie    = 1'b0;
            if (carry_we_i) begin
               flags_d.carry = carry_d_i;
            end
         end
         FLG_RETURN: begin
            flags_d.gie   = flags_q.pgie;
            flags_d.carry = flags_q.pcarry;
         end
         default: begin
            if (gie_clr_i) begin
               flags_d.gie = 1'b0;
            end else if (gie_set_i) begin
               flags_d.gie = 1'b1;
            end
            if (carry_we_i) begin
               flags_d.carry = carry_d_i;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= FLAGS_RESET;
      end else begin
         flags_q <= flags_d;
      end
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
   parameter int unsigned N_MASK     = 4,
   parameter int unsigned PICK_STYLE = 0,
   localparam int unsigned VEC_W     = $clog2(N_MASK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MASK-1:0] req_i,
   input  logic              nmi_i,
   input  logic              defer_i,
   input  logic              reti_i,
   input  logic              gie_set_i,
   input  logic              gie_clr_i,
   input  logic              carry_we_i,
   input  logic              carry_d_i,
   output logic              take_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              gie_o,
   output logic              pgie_o,
   output logic              carry_o,
   output logic              pcarry_o,
   output logic [N_MASK-1:0] pend_o,
   output logic              nmi_pend_o
);
   import intr_prio_pkg::*;

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(N_MASK);

   if (N_MASK < 1 || N_MASK > 15) begin : g_bad_count
      $error("intr_prio_ctrl: N_MASK must lie in 1..15");
   end

   logic [N_MASK-1:0] pend;
   logic [N_MASK-1:0] eligible;
   logic [N_MASK-1:0] win_onehot;
   logic [N_MASK-1:0] mask_clr;
   logic [VEC_W-1:0]  win_idx;
   logic              win_any;
   logic              nmi_pend;
   logic              nmi_take;
   logic              mask_take;
   logic              take;
   flag_set_t         flags;

   intr_req_latch #(.WIDTH(N_MASK)) u_mask_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_i),
      .clr_i  (mask_clr),
      .pend_o (pend)
   );

   intr_req_latch #(.WIDTH(1)) u_nmi_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (nmi_i),
      .clr_i  (nmi_take),
      .pend_o (nmi_pend)
   );

   // Maskable flags only compete while the global enable is on.
   assign eligible = flags.gie ? pend : '0;

   intr_prio_pick #(
      .WIDTH (N_MASK),
      .IDX_W (VEC_W),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .req_i    (eligible),
      .any_o    (win_any),
      .idx_o    (win_idx),
      .onehot_o (win_onehot)
   );

   assign nmi_take  = nmi_pend & ~defer_i;
   assign mask_take = win_any & ~nmi_pend & ~defer_i;
   assign take      = nmi_take | mask_take;
   assign mask_clr  = mask_take ? win_onehot : '0;

   intr_flag_ctrl u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .reti_i     (reti_i),
      .gie_set_i  (gie_set_i),
      .gie_clr_i  (gie_clr_i),
      .carry_we_i (carry_we_i),
      .carry_d_i  (carry_d_i),
      .flags_o    (flags)
   );

   assign take_o     = take;
   assign vec_o      = nmi_pend ? NMI_VEC : win_idx;
   assign gie_o      = flags.gie;
   assign pgie_o     = flags.pgie;
   assign carry_o    = flags.carry;
   assign pcarry_o   = flags.pcarry;
   assign pend_o     = pend;
   assign nmi_pend_o = nmi_pend;

endmodule

// File: rtl/intr_prio_ctrl_chk.sv
module intr_prio_ctrl_chk #(
   parameter int unsigned N_MASK = 4,
   localparam int unsigned VEC_W = $clog2(N_MASK + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_MASK-1:0] req_i,
   input logic              defer_i,
   input logic              reti_i,
   input logic              gie_clr_i,
   input logic              carry_we_i,
   input logic              carry_d_i,
   input logic              take_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic              gie_o,
   input logic              pgie_o,
   input logic              carry_o,
   input logic              pcarry_o,
   input logic [N_MASK-1:0] pend_o,
   input logic              nmi_pend_o
);

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(N_MASK);

   logic [N_MASK-1:0] vec_bit;
   logic [N_MASK-1:0] below_vec;
   assign vec_bit   = N_MASK'(1) << vec_o;
   assign below_vec = vec_bit - N_MASK'(1);

   AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i != '0) |=> ((pend_o & $past(req_i)) == $past(req_i))); // R1

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o != NMI_VEC) |-> ((|(pend_o & vec_bit)) && ((pend_o & below_vec) == '0))); // R2

   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend_o && !defer_i) |-> (take_o && vec_o == NMI_VEC)); // R3

   AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      defer_i |-> !take_o); // R4

   AST_WINNER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o != NMI_VEC && !(|(req_i & vec_bit))) |=> !(|(pend_o & $past(vec_bit)))); // R5

   AST_TAKE_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (!gie_o && pgie_o == $past(gie_o) && pcarry_o == $past(carry_o))); // R6

   AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !take_o) |=> (gie_o == $past(pgie_o) && carry_o == $past(pcarry_o))); // R7

   AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_clr_i && !take_o && !reti_i) |=> !gie_o); // R8

   AST_CARRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_we_i && (take_o || !reti_i)) |=> (carry_o == $past(carry_d_i))); // R9

   AST_MASK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_o && !nmi_pend_o) |-> !take_o); // R11

endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk #(.N_MASK(N_MASK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .defer_i    (defer_i),
   .reti_i     (reti_i),
   .gie_clr_i  (gie_clr_i),
   .carry_we_i (carry_we_i),
   .carry_d_i  (carry_d_i),
   .take_o     (take_o),
   .vec_o      (vec_o),
   .gie_o      (gie_o),
   .pgie_o     (pgie_o),
   .carry_o    (carry_o),
   .pcarry_o   (pcarry_o),
   .pend_o     (pend_o),
   .nmi_pend_o (nmi_pend_o)
);

// File: tb/intr_prio_ctrl_bench.sv
module intr_prio_ctrl_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_i = '0;
   logic         nmi_i = 1'b0;
   logic         defer_i = 1'b0;
   logic         reti_i = 1'b0;
   logic         gie_set_i = 1'b0;
   logic         gie_clr_i = 1'b0;
   logic         carry_we_i = 1'b0;
   logic         carry_d_i = 1'b0;
   logic         take_o;
   logic [2:0]   vec_o;
   logic         gie_o, pgie_o, carry_o, pcarry_o;
   logic [N-1:0] pend_o;
   logic         nmi_pend_o;

   int checks = 0;
   int errors = 0;

   // bench model of the architectural state
   logic [N-1:0] m_pend = '0;
   logic         m_nmi = 1'b0;
   logic         m_gie = 1'b0, m_pgie = 1'b0, m_carry = 1'b0, m_pcarry = 1'b0;

   always #4 clk = ~clk;

   intr_prio_ctrl u_intr_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_i(nmi_i), .defer_i(defer_i),
      .reti_i(reti_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
      .carry_we_i(carry_we_i), .carry_d_i(carry_d_i), .take_o(take_o), .vec_o(vec_o),
      .gie_o(gie_o), .pgie_o(pgie_o), .carry_o(carry_o), .pcarry_o(pcarry_o),
      .pend_o(pend_o), .nmi_pend_o(nmi_pend_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [N-1:0] p);
      for (int i = N - 1; i >= 0; i--) begin
         if (p[i]) lowest = i;
      end
      if (p == '0) lowest = 0;
   endfunction

   // One cycle: drive at the falling edge, check the strobe, update model, check state.
   task automatic cyc(input logic [N-1:0] rq, input logic n, input logic d, input logic rt,
                      input logic gs, input logic gc, input logic cwe, input logic cd);
      logic et;
      int   ev;
      logic ng, npg, nc, npc;
      @(negedge clk);
      req_i = rq; nmi_i = n; defer_i = d; reti_i = rt;
      gie_set_i = gs; gie_clr_i = gc; carry_we_i = cwe; carry_d_i = cd;
      #1;
      et = !d && (m_nmi || (m_gie && m_pend != '0));
      ev = m_nmi ? N : lowest(m_pend);
      chk(d ? "R4 take under defer" : "R5 take strobe", int'(take_o), int'(et));
      if (et) chk(m_nmi ? "R3 nmi vector" : "R2 priority vector", int'(vec_o), ev);
      ng = m_gie; npg = m_pgie; nc = m_carry; npc = m_pcarry;
      if (et) begin
         npg = m_gie; npc = m_carry; ng = 1'b0;
         if (cwe) nc = cd;
      end else if (rt) begin
         ng = m_pgie; nc = m_pcarry;
      end else begin
         if (gc) ng = 1'b0; else if (gs) ng = 1'b1;
         if (cwe) nc = cd;
      end
      if (et) begin
         if (m_nmi) m_nmi = 1'b0;
         else m_pend = m_pend & ~(N'(1) << ev);
      end
      m_pend = m_pend | rq;
      m_nmi  = m_nmi | n;
      m_gie = ng; m_pgie = npg; m_carry = nc; m_pcarry = npc;
      @(posedge clk);
      #1;
      chk("R1 pending flags", int'(pend_o), int'(m_pend));
      chk("R3 nmi latch", int'(nmi_pend_o), int'(m_nmi));
      chk("R8 enable flag", int'(gie_o), int'(m_gie));
      chk("R6 previous enable", int'(pgie_o), int'(m_pgie));
      chk("R9 carry flag", int'(carry_o), int'(m_carry));
      chk("R6 previous carry", int'(pcarry_o), int'(m_pcarry));
      req_i = '0; nmi_i = 0; reti_i = 0; gie_set_i = 0; gie_clr_i = 0; carry_we_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 reset strobe", int'(take_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset pending", int'(pend_o), 0);
      chk("R10 reset nmi", int'(nmi_pend_o), 0);
      chk("R10 reset flags", int'({gie_o, pgie_o, carry_o, pcarry_o}), 0);
      chk("R10 reset strobe", int'(take_o), 0);

      // Sweep every pending pattern, with and without the nonmaskable latch and defer.
      for (int p = 0; p < 16; p++) begin
         for (int n = 0; n < 2; n++) begin
            for (int d = 0; d < 2; d++) begin
               cyc(N'(p), n[0], 0, 0, 0, 1, 0, 0);   // R11: enable off while loading
               cyc('0, 0, 0, 0, 0, 0, 0, 0);         // R11: only the nmi may go
               cyc('0, 0, d[0], 0, 1, 0, 0, 0);      // R8: enable on
               cyc('0, 0, d[0], 0, 0, 0, 0, 0);      // R4: held while deferred
               for (int k = 0; k < 12; k++) begin
                  cyc('0, 0, 0, 0, 1, 0, 0, 0);      // R2/R5 drain in priority order
               end
            end
         end
      end

      // Save and return for every enable/carry combination.
      for (int g = 0; g < 2; g++) begin
         for (int c = 0; c < 2; c++) begin
            cyc('0, 0, 0, 0, g[0], !g[0], 1, c[0]);
            cyc('0, 1, 0, 0, 0, 0, 0, 0);
            cyc('0, 0, 0, 0, 0, 0, 0, 0);            // nmi taken, flags saved
            cyc('0, 0, 0, 0, 1, 0, 1, !c[0]);
            cyc('0, 0, 0, 1, 0, 0, 0, 0);            // return
            chk("R7 enable restored", int'(gie_o), g);
            chk("R7 carry restored", int'(carry_o), c);
         end
      end

      // Precedence corners.
      cyc('0, 0, 0, 0, 1, 1, 0, 0);                 // R8 clear beats set
      chk("R8 clear wins", int'(gie_o), 0);
      cyc('0, 0, 0, 0, 1, 0, 1, 1);
      cyc('0, 1, 0, 0, 0, 0, 0, 0);
      cyc('0, 0, 0, 0, 0, 0, 0, 0);                 // take: pgie=1 pcarry=1
      cyc('0, 0, 0, 1, 0, 0, 1, 0);                 // R9 return beats carry write
      chk("R9 return beats write", int'(carry_o), 1);
      cyc('0, 1, 0, 0, 0, 0, 0, 0);
      cyc('0, 0, 0, 1, 0, 0, 1, 0);                 // R7 take suppresses return, R9 write lands
      chk("R7 return ignored on take", int'(gie_o), 0);
      chk("R9 write during take", int'(carry_o), 0);
      cyc(4'b0010, 0, 0, 0, 1, 0, 0, 0);
      cyc(4'b0010, 0, 0, 0, 0, 0, 0, 0);            // R5 same source re-requested while taken
      chk("R5 re-request survives", int'(pend_o), 2);
      cyc('0, 0, 0, 0, 1, 0, 0, 0);
      cyc('0, 0, 0, 0, 0, 0, 0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule